// File: doc/BRIEF.md
# DDR SDRAM Operating-Mode Register

This block keeps the operating-mode word of a DDR SDRAM device model. The command decoder in front of it reports each command cycle, says whether that command is a mode load, and passes the bank-select bits and the address bus along with it. The bank state machines report which banks are idle. The block checks whether each load is legal. It stores the decoded fields and drives burst length, burst order and CAS latency to the read and write datapaths.

The block reports three kinds of fault, each as a one-cycle pulse:
- a load that breaks the load rules,
- a load that uses a reserved field code,
- any command issued during the wait window that follows an accepted load.

Deep power-down entry empties the register, and so does reset, which stands for loss of power. After either one, the outputs read as invalid until the next legal load.

Top module: `sdram_mode_ctrl`

## Requirements
- R1: After a legal load, the outputs reflect the address fields one cycle after the command edge. Bits 2..0 set the burst length: code 001=2, 010=4, 011=8, 100=16. Bit 3 sets the order: 0=sequential, 1=interleaved. Bits 6..4 set the CAS latency: code 010=2, 011=3. `mode_valid` goes high.
- R2: A load whose `bank_addr` is not zero does not target this register. It changes no output and raises neither `err_illegal` nor `err_reserved`.
- R3: A load to bank 0 with any of address bits 10..7 set pulses `err_illegal` for one cycle and leaves the stored fields unchanged.
- R4: A load to bank 0 while any bit of `banks_idle` is low pulses `err_illegal` and leaves the stored fields unchanged.
- R5: A load to bank 0 with a reserved burst-length code (000, 101, 110, 111) or a reserved latency code (anything other than 010 or 011) pulses `err_reserved` and leaves the stored fields unchanged.
- R6: During and after reset, the outputs are as follows until the first legal load:
  - `mode_valid`, `burst_len`, `burst_ilv`, `cas_lat` and `lock_busy` are 0;
  - no error flag is raised.
- R7: `dpd_enter` clears the register to the invalid state of R6 and ends any wait window. It takes priority over a command in the same cycle.
- R8: An accepted load holds `lock_busy` high for WAIT_CYC cycles (default 2). A command issued while `lock_busy` is high:
  - pulses `err_lockout` one cycle later;
  - is discarded, so a load issued in the window changes nothing.
- R9: The first command issued after the window has closed is processed normally and raises no `err_lockout`.
- R10: The stored fields hold unchanged over any number of idle cycles until the next accepted load, power-down or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power loss) |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_is_load | input | 1 | The issued command is a mode load |
| bank_addr | input | BA_W | Bank-select bits of the command |
| addr | input | ADDR_W | Address bus carrying the mode word |
| banks_idle | input | NUM_BANKS | One bit per bank, high when that bank is idle |
| dpd_enter | input | 1 | Deep power-down entry |
| mode_valid | output | 1 | Register holds a legally loaded value |
| burst_len | output | 5 | Burst length in beats (2, 4, 8, 16), 0 when invalid |
| burst_ilv | output | 1 | 1 = interleaved order, 0 = sequential |
| cas_lat | output | 2 | CAS latency in clocks (2 or 3), 0 when invalid |
| lock_busy | output | 1 | Post-load wait window is running |
| err_illegal | output | 1 | Pulse: load rejected for a nonzero address bit 10..7 or a busy bank |
| err_reserved | output | 1 | Pulse: load rejected for a reserved field code |
| err_lockout | output | 1 | Pulse: command issued inside the wait window |

## Verification
The bound checker watches these properties on every cycle:
- bank-select filtering;
- rejection of illegal and busy-bank loads, with the stored fields held;
- the lockout flag for any command while the window runs;
- clearing on power-down;
- the rule that a valid register only ever shows a supported burst length and latency.

Some behaviour needs the bench's scenarios and computed expectations. This covers:
- the exact mapping from each code to its field value;
- the length of the window, and the normal handling of the first command after it;
- the priority of power-down over a load in the same cycle;
- retention of the fields across long idle stretches.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

    // Largest burst-length code; the length is 1 << code.
    localparam int unsigned BL_MAX_CODE = 4;
    localparam int unsigned BLEN_W      = BL_MAX_CODE + 1;
    localparam int unsigned CL_W        = 2;

    // Field positions inside the mode word.
    localparam int unsigned BL_LSB  = 0;
    localparam int unsigned ORD_BIT = 3;
    localparam int unsigned CL_LSB  = 4;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned ZERO_LSB = 7;

    // Supported CAS latency codes.
    localparam logic [CODE_W-1:0] CL_CODE_MIN = 3'd2;
    localparam logic [CODE_W-1:0] CL_CODE_MAX = 3'd3;

    typedef struct packed {
        logic              valid;
        logic [BLEN_W-1:0] blen;
        logic              ilv;
        logic [CL_W-1:0]   cl;
    } mode_fields_t;

    typedef struct packed {
        logic illegal;
        logic reserved;
        logic lockout;
    } mode_errs_t;

endpackage

// File: rtl/mode_field_decode.sv
module mode_field_decode
    import sdram_mode_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] word,
    output logic [BLEN_W-1:0] blen,
    output logic              ilv,
    output logic [CL_W-1:0]   cl,
    output logic              bl_rsv,
    output logic              cl_rsv,
    output logic              high_nz
);
    localparam int unsigned HI_W = ADDR_W - ZERO_LSB;

    logic [CODE_W-1:0] bl_code;
    logic [CODE_W-1:0] cl_code;
    logic [HI_W-1:0]   hi_bits;

    assign bl_code = word[BL_LSB +: CODE_W];
    assign cl_code = word[CL_LSB +: CODE_W];
    assign hi_bits = word[ADDR_W-1:ZERO_LSB];

    always_comb begin
        bl_rsv = 1'b1;
        blen   = '0;
        if ((bl_code != '0) && (32'(bl_code) <= BL_MAX_CODE)) begin
            bl_rsv = 1'b0;
            blen   = BLEN_W'(1) << bl_code;
        end
    end

    always_comb begin
        cl_rsv = 1'b1;
        cl     = '0;
        if ((cl_code >= CL_CODE_MIN) && (cl_code <= CL_CODE_MAX)) begin
            cl_rsv = 1'b0;
            cl     = cl_code[CL_W-1:0];
        end
    end

    assign ilv     = word[ORD_BIT];
    assign high_nz = |hi_bits;

endmodule

// File: rtl/mode_lockout_timer.sv
module mode_lockout_timer #(
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdram_mode_ctrl.sv
module sdram_mode_ctrl
    import sdram_mode_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned WAIT_CYC  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_load,
    input  logic [BA_W-1:0]      bank_addr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] banks_idle,
    input  logic                 dpd_enter,
    output logic                 mode_valid,
    output logic [BLEN_W-1:0]    burst_len,
    output logic                 burst_ilv,
    output logic [CL_W-1:0]      cas_lat,
    output logic                 lock_busy,
    output logic                 err_illegal,
    output logic                 err_reserved,
    output logic                 err_lockout
);
    typedef struct packed {
        mode_fields_t mode;
        mode_errs_t   errs;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [BLEN_W-1:0] dec_blen;
    logic              dec_ilv;
    logic [CL_W-1:0]   dec_cl;
    logic              dec_bl_rsv, dec_cl_rsv, dec_high_nz;

    logic load_cmd, blocked, targeted, bad_load, rsv_load, accept;

    mode_field_decode #(.ADDR_W(ADDR_W)) u_decode (
        .word    (addr),
        .blen    (dec_blen),
        .ilv     (dec_ilv),
        .cl      (dec_cl),
        .bl_rsv  (dec_bl_rsv),
        .cl_rsv  (dec_cl_rsv),
        .high_nz (dec_high_nz)
    );

    mode_lockout_timer #(.WAIT_CYC(WAIT_CYC)) u_lockout (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dpd_enter),
        .start (accept),
        .busy  (lock_busy)
    );

    always_comb begin
        load_cmd = cmd_valid && cmd_is_load;
        blocked  = cmd_valid && lock_busy;
        targeted = load_cmd && !blocked && (bank_addr == '0) && !dpd_enter;
        bad_load = targeted && (dec_high_nz || !(&banks_idle));
        rsv_load = targeted && (dec_bl_rsv || dec_cl_rsv);
        accept   = targeted && !bad_load && !rsv_load;

        st_d              = st_q;
        st_d.errs.illegal  = bad_load;
        st_d.errs.reserved = rsv_load;
        st_d.errs.lockout  = blocked && !dpd_enter;

        if (dpd_enter) begin
            st_d.mode = '0;
        end else if (accept) begin
            st_d.mode.valid = 1'b1;
            st_d.mode.blen  = dec_blen;
            st_d.mode.ilv   = dec_ilv;
            st_d.mode.cl    = dec_cl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_valid   = st_q.mode.valid;
    assign burst_len    = st_q.mode.blen;
    assign burst_ilv    = st_q.mode.ilv;
    assign cas_lat      = st_q.mode.cl;
    assign err_illegal  = st_q.errs.illegal;
    assign err_reserved = st_q.errs.reserved;
    assign err_lockout  = st_q.errs.lockout;

endmodule

// File: rtl/sdram_mode_ctrl_chk.sv
module sdram_mode_ctrl_chk
    import sdram_mode_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_is_load,
    input logic [BA_W-1:0]      bank_addr,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_BANKS-1:0] banks_idle,
    input logic                 dpd_enter,
    input logic                 mode_valid,
    input logic [BLEN_W-1:0]    burst_len,
    input logic                 burst_ilv,
    input logic [CL_W-1:0]      cas_lat,
    input logic                 lock_busy,
    input logic                 err_illegal,
    input logic                 err_reserved,
    input logic                 err_lockout
);
    logic [BLEN_W+CL_W+1:0] fields;
    logic free_load;
    assign fields    = {mode_valid, burst_len, burst_ilv, cas_lat};
    assign free_load = cmd_valid && cmd_is_load && !lock_busy && !dpd_enter;

    assert_legal_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> ($onehot(burst_len) && !burst_len[0] && cas_lat[1]));

    assert_other_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_load && bank_addr != '0) |=> ($stable(fields) && !err_illegal && !err_reserved));

    assert_high_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_load && bank_addr == '0 && (|addr[ADDR_W-1:7])) |=> (err_illegal && $stable(fields)));

    assert_busy_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_load && bank_addr == '0 && !(&banks_idle)) |=> (err_illegal && $stable(fields)));

    assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (burst_len == '0 && cas_lat == '0 && !burst_ilv));

    assert_dpd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_enter |=> (!mode_valid && !lock_busy && !err_lockout));

    assert_lockout_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && lock_busy && !dpd_enter) |=> (err_lockout && $stable(fields)));

    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_valid) |-> $past(dpd_enter));

endmodule

bind sdram_mode_ctrl sdram_mode_ctrl_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_BANKS(NUM_BANKS)
) u_chk (.*);

// File: tb/sdram_mode_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_mode_ctrl_tb;
    localparam int ADDR_W = 11;
    localparam int BA_W = 2;
    localparam int NB = 4;
    localparam int WAIT_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_is_load = 1'b0, dpd_enter = 1'b0;
    logic [BA_W-1:0] bank_addr = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NB-1:0] banks_idle = '1;
    logic mode_valid, burst_ilv, lock_busy, err_illegal, err_reserved, err_lockout;
    logic [4:0] burst_len;
    logic [1:0] cas_lat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_mode_ctrl #(.ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_BANKS(NB), .WAIT_CYC(WAIT_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_load(cmd_is_load),
        .bank_addr(bank_addr), .addr(addr), .banks_idle(banks_idle), .dpd_enter(dpd_enter),
        .mode_valid(mode_valid), .burst_len(burst_len), .burst_ilv(burst_ilv),
        .cas_lat(cas_lat), .lock_busy(lock_busy), .err_illegal(err_illegal),
        .err_reserved(err_reserved), .err_lockout(err_lockout));

    typedef struct packed {
        logic [1:0]  bank;
        logic [3:0]  idle;
        logic [10:0] a;
        logic        e_ill;
        logic        e_rsv;
        logic        e_val;
        logic [4:0]  e_bl;
        logic        e_il;
        logic [1:0]  e_cl;
    } vec_t;

    // Expected state is what the register must hold after the vector.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'hF, 11'h022, 1'b0, 1'b0, 1'b1, 5'd4,  1'b0, 2'd2}, // R1 BL4 seq CL2
        '{2'd0, 4'hF, 11'h03C, 1'b0, 1'b0, 1'b1, 5'd16, 1'b1, 2'd3}, // R1 BL16 ilv CL3
        '{2'd0, 4'hF, 11'h031, 1'b0, 1'b0, 1'b1, 5'd2,  1'b0, 2'd3}, // R1 BL2 seq CL3
        '{2'd0, 4'hF, 11'h02B, 1'b0, 1'b0, 1'b1, 5'd8,  1'b1, 2'd2}, // R1 BL8 ilv CL2
        '{2'd0, 4'hF, 11'h025, 1'b0, 1'b1, 1'b1, 5'd8,  1'b1, 2'd2}, // R5 BL code 101
        '{2'd0, 4'hF, 11'h012, 1'b0, 1'b1, 1'b1, 5'd8,  1'b1, 2'd2}, // R5 CL code 001
        '{2'd0, 4'hF, 11'h222, 1'b1, 1'b0, 1'b1, 5'd8,  1'b1, 2'd2}, // R3 bit 9 set
        '{2'd0, 4'hB, 11'h022, 1'b1, 1'b0, 1'b1, 5'd8,  1'b1, 2'd2}, // R4 bank 2 busy
        '{2'd1, 4'hF, 11'h031, 1'b0, 1'b0, 1'b1, 5'd8,  1'b1, 2'd2}, // R2 bank 1
        '{2'd0, 4'hF, 11'h020, 1'b0, 1'b1, 1'b1, 5'd8,  1'b1, 2'd2}, // R5 BL code 000
        '{2'd0, 4'hF, 11'h029, 1'b0, 1'b0, 1'b1, 5'd2,  1'b1, 2'd2}, // R1 BL2 ilv CL2
        '{2'd2, 4'h3, 11'h7FF, 1'b0, 1'b0, 1'b1, 5'd2,  1'b1, 2'd2}  // R2 bank 2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at the current falling edge, release and return one cycle later.
    task automatic issue(input logic v, input logic ld, input logic [1:0] ba,
                         input logic [10:0] a, input logic [3:0] idle, input logic pd);
        cmd_valid = v; cmd_is_load = ld; bank_addr = ba; addr = a;
        banks_idle = idle; dpd_enter = pd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_is_load = 1'b0; bank_addr = '0; addr = '0;
        banks_idle = '1; dpd_enter = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_mode(input string req, input logic v, input logic [4:0] bl,
                            input logic il, input logic [1:0] cl);
        chk(req, {mode_valid, burst_len, burst_ilv, cas_lat}, {v, bl, il, cl});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_cycles(3);
        chk_mode("R6 reset fields", mode_valid, 5'd0, 1'b0, 2'd0);
        chk("R6 reset valid", mode_valid, 0);
        chk("R6 reset flags", {lock_busy, err_illegal, err_reserved, err_lockout}, 0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk("R6 invalid after reset", {mode_valid, burst_len, cas_lat}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            issue(1'b1, 1'b1, VECS[i].bank, VECS[i].a, VECS[i].idle, 1'b0);
            chk($sformatf("R3/R4/R5 vec%0d flags", i), {err_illegal, err_reserved, err_lockout},
                {VECS[i].e_ill, VECS[i].e_rsv, 1'b0});
            idle_cycles(3);
            chk_mode($sformatf("R1/R2 vec%0d fields", i), VECS[i].e_val, VECS[i].e_bl,
                     VECS[i].e_il, VECS[i].e_cl);
        end

        // R8 lockout window
        issue(1'b1, 1'b1, 2'd0, 11'h022, 4'hF, 1'b0);
        chk("R8 busy after load", lock_busy, 1);
        chk_mode("R1 load before window", 1'b1, 5'd4, 1'b0, 2'd2);
        issue(1'b1, 1'b0, 2'd0, 11'h000, 4'hF, 1'b0);
        chk("R8 cmd in window flagged", err_lockout, 1);
        chk("R8 busy second cycle", lock_busy, 1);
        issue(1'b1, 1'b1, 2'd0, 11'h03C, 4'hF, 1'b0);
        chk("R8 load in window flagged", err_lockout, 1);
        chk_mode("R8 load in window discarded", 1'b1, 5'd4, 1'b0, 2'd2);
        chk("R8 window closed", lock_busy, 0);
        issue(1'b1, 1'b1, 2'd0, 11'h03C, 4'hF, 1'b0);
        chk("R9 first cmd after window", err_lockout, 0);
        chk_mode("R9 load after window accepted", 1'b1, 5'd16, 1'b1, 2'd3);

        // R10 retention
        idle_cycles(40);
        chk_mode("R10 hold over idle", 1'b1, 5'd16, 1'b1, 2'd3);

        // R7 power-down wins over same-cycle load
        issue(1'b1, 1'b1, 2'd0, 11'h022, 4'hF, 1'b1);
        chk_mode("R7 dpd clears", 1'b0, 5'd0, 1'b0, 2'd0);
        chk("R7 dpd flags", {lock_busy, err_illegal, err_reserved, err_lockout}, 0);
        issue(1'b1, 1'b1, 2'd0, 11'h031, 4'hF, 1'b0);
        idle_cycles(3);
        chk_mode("R1 load after dpd", 1'b1, 5'd2, 1'b0, 2'd3);

        // R7 power-down ends the window
        issue(1'b1, 1'b1, 2'd0, 11'h02B, 4'hF, 1'b0);
        issue(1'b0, 1'b0, 2'd0, 11'h000, 4'hF, 1'b1);
        chk("R7 dpd ends window", lock_busy, 0);
        issue(1'b1, 1'b0, 2'd0, 11'h000, 4'hF, 1'b0);
        chk("R7 no lockout after dpd", err_lockout, 0);

        // R6 reset mid-run
        issue(1'b1, 1'b1, 2'd0, 11'h022, 4'hF, 1'b0);
        idle_cycles(3);
        rst_n = 1'b0;
        idle_cycles(1);
        chk_mode("R6 reset clears", 1'b0, 5'd0, 1'b0, 2'd0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk("R6 stays invalid", mode_valid, 0);

        finish_run();
    end
endmodule